// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter with Chained Carry

This block is a synchronous binary counter, four bits wide by default, whose state bits all change together on the rising clock edge. It can be preset from a parallel data word, counts in either direction, and holds its value when counting is not enabled. Software-free control comes entirely from level inputs that are sampled at the clock edge: an active-low load, a direction select and two active-low count enables.

The two enables differ in reach. The local enable only gates counting. The chain enable gates counting and also the active-low carry output, which is low while the count sits at its terminal value for the selected direction. The terminal value is the all-ones value when counting up and zero when counting down. Wider counters are built by feeding one stage's carry into the next stage's chain enable, so that the upper stage advances only on the cycle in which the lower one wraps.

A synchronous reset clears the count for start-up; there is no asynchronous clear. Reset takes precedence over load, and load takes precedence over counting.

Top module: `updown_preset_counter`

## Requirements
- R1: When `srst` is high at a rising edge, `count` is 0 after that edge, whatever the other inputs are.
- R2: When `srst` is low and `load_n` is low at a rising edge, `count` takes the value of `din` after that edge; `dir_up`, `en_loc_n` and `en_chain_n` have no effect on that edge.
- R3: When `srst` and `load_n` do not act and either `en_loc_n` or `en_chain_n` is high at a rising edge, `count` keeps its value.
- R4: When `srst` and `load_n` do not act and both enables are low, `count` becomes count+1 modulo 2^WIDTH if `dir_up` is 1 and count-1 modulo 2^WIDTH if `dir_up` is 0, so 15 goes to 0 upward and 0 goes to 15 downward at WIDTH=4.
- R5: `carry_n` is 0 exactly when `en_chain_n` is 0 and either `dir_up` is 1 with `count` equal to 2^WIDTH-1, or `dir_up` is 0 with `count` equal to 0; otherwise it is 1. It is combinational and follows `dir_up` and `en_chain_n` within the same cycle.
- R6: `en_loc_n` has no effect on `carry_n`.
- R7: Starting from a load of 13, counting up gives 14, 15, 0, 1, 2 with `carry_n` low only while at 15; holding with an enable high keeps 2; counting down then gives 1, 0, 15, 14, 13 with `carry_n` low only while at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| srst | input | 1 | Synchronous reset, active high, clears the count |
| load_n | input | 1 | Synchronous preset, active low |
| din | input | WIDTH | Parallel preset value |
| dir_up | input | 1 | Count direction: 1 up, 0 down |
| en_loc_n | input | 1 | Local count enable, active low, gates counting only |
| en_chain_n | input | 1 | Chain count enable, active low, gates counting and the carry |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal-count carry, active low |

## Verification
The clocked properties assume that every control and data input is settled at each rising edge and that reset is applied at the first edge, so that the count is known before any step or hold rule is judged. The stimulus changes inputs only on the falling edge and asserts `srst` from time zero. The carry property is sampled at the edge as well, so it assumes `dir_up` and `en_chain_n` change only between edges; the bench keeps to that while still checking the carry right after each falling-edge change of those inputs.

// File: rtl/ctr_pkg.sv
`timescale 1ns/1ps
package ctr_pkg;

    // Action selected for the next rising edge, in priority order.
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_CLEAR = 3'd1,
        ACT_LOAD  = 3'd2,
        ACT_UP    = 3'd3,
        ACT_DOWN  = 3'd4
    } ctr_act_e;

endpackage

// File: rtl/ctr_act_decode.sv
`timescale 1ns/1ps
module ctr_act_decode
    import ctr_pkg::*;
(
    input  logic     srst,
    input  logic     load_n,
    input  logic     dir_up,
    input  logic     en_loc_n,
    input  logic     en_chain_n,
    output ctr_act_e act
);

    logic run;

    assign run = ~en_loc_n & ~en_chain_n;

    always_comb begin
        if (srst) begin
            act = ACT_CLEAR;
        end else if (!load_n) begin
            act = ACT_LOAD;
        end else if (run) begin
            act = dir_up ? ACT_UP : ACT_DOWN;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/ctr_step.sv
`timescale 1ns/1ps
// Look-ahead step: bit i toggles when every lower bit is at the
// terminal level for the chosen direction.
module ctr_step #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    output logic [WIDTH-1:0] nxt
);

    logic [WIDTH:0] low_ones;
    logic [WIDTH:0] low_zeros;

    assign low_ones[0]  = 1'b1;
    assign low_zeros[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign low_ones[i+1]  = low_ones[i]  &  cur[i];
        assign low_zeros[i+1] = low_zeros[i] & ~cur[i];
        assign nxt[i] = cur[i] ^ (up ? low_ones[i] : low_zeros[i]);
    end

endmodule

// File: rtl/ctr_terminal.sv
`timescale 1ns/1ps
module ctr_terminal #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    input  logic             en_chain_n,
    output logic             carry_n
);

    logic at_top;
    logic at_bottom;

    assign at_top    = &cur;
    assign at_bottom = ~|cur;

    always_comb begin
        carry_n = 1'b1;
        if (!en_chain_n) begin
            carry_n = up ? ~at_top : ~at_bottom;
        end
    end

endmodule

// File: rtl/updown_preset_counter.sv
`timescale 1ns/1ps
module updown_preset_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             dir_up,
    input  logic             en_loc_n,
    input  logic             en_chain_n,
    output logic [WIDTH-1:0] count,
    output logic             carry_n
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } ctr_state_t;

    ctr_state_t       state_d;
    ctr_state_t       state_q;
    ctr_act_e         act_d;
    logic [WIDTH-1:0] stepped_d;

    ctr_act_decode u_dec (
        .srst       (srst),
        .load_n     (load_n),
        .dir_up     (dir_up),
        .en_loc_n   (en_loc_n),
        .en_chain_n (en_chain_n),
        .act        (act_d)
    );

    ctr_step #(.WIDTH(WIDTH)) u_step (
        .cur (state_q.cnt),
        .up  (dir_up),
        .nxt (stepped_d)
    );

    ctr_terminal #(.WIDTH(WIDTH)) u_term (
        .cur        (state_q.cnt),
        .up         (dir_up),
        .en_chain_n (en_chain_n),
        .carry_n    (carry_n)
    );

    always_comb begin
        state_d = state_q;
        case (act_d)
            ACT_CLEAR: state_d.cnt = '0;
            ACT_LOAD:  state_d.cnt = din;
            ACT_UP,
            ACT_DOWN:  state_d.cnt = stepped_d;
            default:   state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q.cnt;

endmodule

// File: rtl/ctr_props.sv
`timescale 1ns/1ps
module ctr_props #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             srst,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             dir_up,
    input logic             en_loc_n,
    input logic             en_chain_n,
    input logic [WIDTH-1:0] count,
    input logic             carry_n
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    bit primed = 1'b0;

    always_ff @(posedge clk) begin
        if (srst) primed <= 1'b1;
    end

    assert_clear_R1: assert property (@(posedge clk)
        srst |=> count == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (!primed || srst)
        !load_n |=> count == $past(din));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!primed || srst)
        (load_n && (en_loc_n || en_chain_n)) |=> $stable(count));

    assert_up_wrap_R4: assert property (@(posedge clk) disable iff (!primed || srst)
        (load_n && !en_loc_n && !en_chain_n && dir_up)
        |=> count == WIDTH'($past(count) + 1'b1));

    assert_down_wrap_R4: assert property (@(posedge clk) disable iff (!primed || srst)
        (load_n && !en_loc_n && !en_chain_n && !dir_up)
        |=> count == WIDTH'($past(count) - 1'b1));

    assert_carry_level_R5: assert property (@(posedge clk) disable iff (!primed)
        carry_n == !(!en_chain_n && (dir_up ? (count == TOP) : (count == '0))));

    assert_loc_no_carry_R6: assert property (@(posedge clk) disable iff (!primed)
        ($stable(count) && $stable(dir_up) && $stable(en_chain_n) && !$stable(en_loc_n))
        |-> $stable(carry_n));

endmodule

bind updown_preset_counter ctr_props #(.WIDTH(WIDTH)) u_props (.*);

// File: tb/sim_updown_preset_counter.sv
`timescale 1ns/1ps
module sim_updown_preset_counter;

    localparam int W    = 4;
    localparam int MODV = 1 << W;

    logic         clk = 1'b0;
    logic         srst, load_n, dir_up, en_loc_n, en_chain_n;
    logic [W-1:0] din;
    logic [W-1:0] count;
    logic         carry_n;

    int vectors   = 0;
    int miscomp   = 0;
    int exp_cnt   = 0;
    bit finished  = 1'b0;

    always #2 clk = ~clk;

    updown_preset_counter #(.WIDTH(W)) u0 (
        .clk(clk), .srst(srst), .load_n(load_n), .din(din), .dir_up(dir_up),
        .en_loc_n(en_loc_n), .en_chain_n(en_chain_n),
        .count(count), .carry_n(carry_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscomp++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_carry(input int c, input bit up, input bit chain_n);
        if (chain_n) return 1;
        if (up && c == MODV - 1) return 0;
        if (!up && c == 0) return 0;
        return 1;
    endfunction

    // Drive at the falling edge, check carry there, check count after the rising edge.
    task automatic cyc(input string req, input bit rs, input bit ld_n, input int d,
                       input bit up, input bit el_n, input bit ec_n);
        @(negedge clk);
        srst = rs; load_n = ld_n; din = W'(d); dir_up = up;
        en_loc_n = el_n; en_chain_n = ec_n;
        #1;
        chk(el_n ? "R5/R6 carry" : "R5 carry", int'(carry_n), exp_carry(exp_cnt, up, ec_n));
        if (rs)                   exp_cnt = 0;
        else if (!ld_n)           exp_cnt = d;
        else if (!el_n && !ec_n)  exp_cnt = up ? (exp_cnt + 1) % MODV : (exp_cnt + MODV - 1) % MODV;
        @(posedge clk);
        #1;
        chk(req, int'(count), exp_cnt);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            miscomp++;
            vectors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        srst = 1'b1; load_n = 1'b1; din = '0; dir_up = 1'b1;
        en_loc_n = 1'b0; en_chain_n = 1'b0;
        @(posedge clk);
        #1;
        exp_cnt = 0;
        chk("R1 reset", int'(count), 0);

        // R1 reset beats load
        cyc("R1 reset over load", 1'b1, 1'b0, 9, 1'b1, 1'b0, 1'b0);

        // R7 reference sequence
        cyc("R7 load 13", 1'b0, 1'b0, 13, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 5; k++) cyc("R7 up", 1'b0, 1'b1, 0, 1'b1, 1'b0, 1'b0);
        chk("R7 at 2", int'(count), 2);
        for (int k = 0; k < 2; k++) cyc("R7 inhibit", 1'b0, 1'b1, 0, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++) cyc("R7 down", 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0);
        chk("R7 at 13", int'(count), 13);

        // Sweep: every preset, direction and enable pair
        for (int v = 0; v < MODV; v++) begin
            for (int up = 0; up < 2; up++) begin
                for (int en = 0; en < 4; en++) begin
                    cyc("R2 load", 1'b0, 1'b0, v, bit'(up), bit'(en & 1), bit'(en >> 1));
                    cyc((en == 0) ? "R4 step" : "R3 hold", 1'b0, 1'b1, (v + 5) % MODV,
                        bit'(up), bit'(en & 1), bit'(en >> 1));
                end
            end
        end

        // R2 load wins over an active count, both directions
        cyc("R2 load", 1'b0, 1'b0, 15, 1'b0, 1'b0, 1'b0);
        cyc("R2 load priority", 1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0);
        cyc("R4 wrap down", 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0);
        cyc("R4 wrap up", 1'b0, 1'b1, 0, 1'b1, 1'b0, 1'b0);

        // R5 carry follows direction and chain enable within a cycle
        cyc("R2 load", 1'b0, 1'b0, 15, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        load_n = 1'b1; en_loc_n = 1'b1; en_chain_n = 1'b0; dir_up = 1'b1;
        #1 chk("R5 top up", int'(carry_n), 0);
        dir_up = 1'b0;
        #0.5 chk("R5 top down", int'(carry_n), 1);
        @(negedge clk);
        dir_up = 1'b1; en_chain_n = 1'b1;
        #1 chk("R5 chain off", int'(carry_n), 1);
        @(negedge clk);
        en_chain_n = 1'b0; en_loc_n = 1'b0;
        #1 chk("R6 local enable", int'(carry_n), 0);
        en_loc_n = 1'b1;
        @(posedge clk);
        #1 chk("R3 held", int'(count), 15);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule